// File: doc/BRIEF.md
# Interlaced Serializer with Comma Insertion

This block turns a 20-bit parallel word into a serial bit stream clocked by a bit-rate clock. It saves power the way a fast serializer does: the word is split across two ten-bit shift banks that each move only every second bit time, and one full-rate output flop picks from the two bank heads in turn. In half-rate mode only the lower ten bits are sent. They go out of a single bank, and each bit is held for two bit-clock cycles. The frame is twenty bit-clock cycles long in both modes.

A frame strobe marks the cycle in which the block samples the next parallel word and the mode inputs. A word sampled during one frame goes out during the following frame. A test mode replaces the data with a fixed comma code word, so that a receiver can align its bytes without any upper-layer logic. A ping-pong mode lets the host present the upper ten bits one bit-clock cycle after the lower ten, which spreads out the switching of the parallel bus. All slower timing is made from clock enables that count the bit clock: a divide-by-2 stage, then divide-by-2 and divide-by-5 stages in full-rate mode, or divide-by-5 and divide-by-2 stages in half-rate mode.

Top module: `ilv_serializer`

## Requirements
- R1: While reset is held low, `ser_o` and `frame_strobe_o` are 0. After reset is released, the first `frame_strobe_o` pulse is seen in the 20th bit-clock cycle, and the serial output stays 0 until the first sampled word is sent.
- R2: `frame_strobe_o` is high for exactly one bit-clock cycle in every 20, whatever the mode.
- R3: With `full_rate_i`=1 at the strobe, the word is sent in the next frame as 20 bits. Bit k of `par_data_i` (k=0..19) appears on `ser_o` in the cycle k+1 after the next strobe. So the lower ten bits go first, least significant bit first, then the upper ten.
- R4: With `full_rate_i`=0 at the strobe, only `par_data_i[9:0]` is sent. Bit j appears in cycles 2j+1 and 2j+2 after the next strobe. The upper ten bits have no effect on `ser_o`.
- R5: With `comma_en_i`=1 at the strobe, each ten-bit group that is sent is replaced by the comma word. Its bits leave first-to-last as 0,0,1,1,1,1,1,0,1,0, which is the ten-bit value 0x17C sent least significant bit first. Full-rate mode sends two copies and half-rate mode sends one.
- R6: With `pingpong_i`=1 at the strobe, `par_data_i[19:10]` is sampled one bit-clock cycle after the strobe cycle instead of in it. `par_data_i[9:0]` is still sampled in the strobe cycle.
- R7: With `pingpong_i`=0 at the strobe, the upper ten bits are sampled in the strobe cycle. A change to them in the following cycle has no effect on `ser_o`.
- R8: `full_rate_i`, `comma_en_i`, `pingpong_i` and the data are sampled only at the strobe (the upper bits also in the cycle after it, when R6 applies). Changes at any other time have no effect. A new rate takes effect only at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_data_i | input | 20 | Parallel word: bits 9:0 lower group, bits 19:10 upper group |
| full_rate_i | input | 1 | 1 selects 20 bits per frame, 0 selects 10 bits at half rate |
| comma_en_i | input | 1 | Sends the comma word instead of data |
| pingpong_i | input | 1 | Samples the upper group one cycle after the strobe |
| ser_o | output | 1 | Serial data |
| frame_strobe_o | output | 1 | One-cycle pulse in the cycle where inputs are sampled |

## Verification
The bench builds the block with its default group width of ten, so one frame is twenty cycles long. Mode and comma choices change from frame to frame, which runs both divider orders and both kinds of mode switch at the frame boundary. Random words and modes, with the inputs scrambled in the middle of each frame, bring within reach the cases where a wrong sampling cycle, a swapped bank order or a mode that leaks into the wrong frame changes the serial stream.

// File: rtl/ilv_ser_pkg.sv
package ilv_ser_pkg;

    typedef enum logic {
        RATE_HALF = 1'b0,
        RATE_FULL = 1'b1
    } rate_e;

    // Comma code word, stored so that bit 0 leaves the serializer first.
    localparam int                 COMMA_W    = 10;
    localparam logic [COMMA_W-1:0] COMMA_SEND = 10'b0101111100;

    // Modulus of the second and third divider stages for a given rate.
    function automatic int stage_mod(input rate_e rate, input int stage, input int half_group);
        if (rate == RATE_FULL) begin
            return (stage == 2) ? 2 : half_group;
        end
        return (stage == 2) ? half_group : 2;
    endfunction

endpackage

// File: rtl/ilv_ser_clkgen.sv
module ilv_ser_clkgen
    import ilv_ser_pkg::*;
#(
    parameter int GROUP_W = 10
) (
    input  logic  clk,
    input  logic  rst_n,
    input  rate_e rate_i,
    output logic  phase_o,
    output logic  frame_end_o,
    output logic  strobe_o,
    output logic  strobe_dly_o
);
    localparam int HALF_G  = GROUP_W / 2;
    localparam int CW      = (HALF_G > 2) ? $clog2(HALF_G) : 1;
    localparam int FRAME_N = 2 * GROUP_W;
    localparam int GAP_W   = $clog2(FRAME_N) + 1;

    typedef struct packed {
        logic          s1;
        logic [CW-1:0] s2;
        logic [CW-1:0] s3;
        logic          strobe;
        logic          strobe_dly;
    } cg_t;

    cg_t           cg_d, cg_q;
    logic [CW-1:0] last2, last3;
    logic          wrap1, wrap2, wrap3;

    always_comb begin
        cg_d  = cg_q;
        last2 = CW'(stage_mod(rate_i, 2, HALF_G) - 1);
        last3 = CW'(stage_mod(rate_i, 3, HALF_G) - 1);
        wrap1 = cg_q.s1;
        wrap2 = wrap1 && (cg_q.s2 == last2);
        wrap3 = wrap2 && (cg_q.s3 == last3);

        cg_d.s1 = ~cg_q.s1;
        if (wrap1) begin
            cg_d.s2 = (cg_q.s2 == last2) ? '0 : cg_q.s2 + 1'b1;
        end
        if (wrap2) begin
            cg_d.s3 = (cg_q.s3 == last3) ? '0 : cg_q.s3 + 1'b1;
        end
        cg_d.strobe     = wrap3;
        cg_d.strobe_dly = cg_q.strobe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cg_q <= '0;
        end else begin
            cg_q <= cg_d;
        end
    end

    assign phase_o      = cg_q.s1;
    assign frame_end_o  = wrap3;
    assign strobe_o     = cg_q.strobe;
    assign strobe_dly_o = cg_q.strobe_dly;

    // Checker: cycles since the previous strobe.
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (cg_q.strobe) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    a_r2_strobe_period: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && seen_q) |-> (gap_q == GAP_W'(FRAME_N - 1)));

    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

endmodule

// File: rtl/ilv_ser_capture.sv
module ilv_ser_capture
    import ilv_ser_pkg::*;
#(
    parameter int                 GROUP_W    = 10,
    parameter logic [GROUP_W-1:0] COMMA_WORD = COMMA_SEND
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe_i,
    input  logic               strobe_dly_i,
    input  logic [GROUP_W-1:0] lo_i,
    input  logic [GROUP_W-1:0] hi_i,
    input  logic               full_i,
    input  logic               comma_i,
    input  logic               pp_i,
    output logic [GROUP_W-1:0] lo_o,
    output logic [GROUP_W-1:0] hi_o,
    output rate_e              rate_o
);
    typedef struct packed {
        logic [GROUP_W-1:0] lo;
        logic [GROUP_W-1:0] hi;
        rate_e              rate;
        logic               comma;
        logic               pp;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (strobe_i) begin
            cap_d.lo    = comma_i ? COMMA_WORD : lo_i;
            cap_d.rate  = full_i ? RATE_FULL : RATE_HALF;
            cap_d.comma = comma_i;
            cap_d.pp    = pp_i;
            if (!pp_i) begin
                cap_d.hi = comma_i ? COMMA_WORD : hi_i;
            end
        end
        if (strobe_dly_i && cap_q.pp) begin
            cap_d.hi = cap_q.comma ? COMMA_WORD : hi_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q      <= '0;
            cap_q.rate <= RATE_FULL;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign lo_o   = cap_q.lo;
    assign hi_o   = cap_q.hi;
    assign rate_o = cap_q.rate;

    a_r5_comma_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && comma_i) |=> (cap_q.lo == COMMA_WORD));

    a_r6_late_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_dly_i && cap_q.pp && !cap_q.comma) |=> (cap_q.hi == $past(hi_i)));

    a_r7_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_dly_i && !cap_q.pp) |=> $stable(cap_q.hi));

    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> ($stable(cap_q.rate) && $stable(cap_q.comma) && $stable(cap_q.pp)));

endmodule

// File: rtl/ilv_ser_bank.sv
module ilv_ser_bank #(
    parameter int GROUP_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [GROUP_W-1:0] load_val_i,
    output logic               head_o
);
    typedef struct packed {
        logic [GROUP_W-1:0] sr;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load_i) begin
            bank_d.sr = load_val_i;
        end else if (shift_i) begin
            bank_d.sr = {1'b0, bank_q.sr[GROUP_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign head_o = bank_q.sr[0];

endmodule

// File: rtl/ilv_serializer.sv
module ilv_serializer
    import ilv_ser_pkg::*;
#(
    parameter int                 GROUP_W    = 10,
    parameter logic [GROUP_W-1:0] COMMA_WORD = COMMA_SEND,
    localparam int                WORD_W     = 2 * GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] par_data_i,
    input  logic              full_rate_i,
    input  logic              comma_en_i,
    input  logic              pingpong_i,
    output logic              ser_o,
    output logic              frame_strobe_o
);
    localparam int N_BANKS = 2;

    typedef struct packed {
        rate_e rate;
        logic  ser;
    } top_t;

    top_t top_d, top_q;

    logic               phase, frame_end, strobe, strobe_dly;
    logic [GROUP_W-1:0] cap_lo, cap_hi;
    rate_e              cap_rate;
    logic [WORD_W-1:0]  word;
    logic               bank_shift;
    logic [GROUP_W-1:0] bank_val  [N_BANKS];
    logic               bank_head [N_BANKS];

    ilv_ser_clkgen #(
        .GROUP_W (GROUP_W)
    ) clkgen_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_i       (top_q.rate),
        .phase_o      (phase),
        .frame_end_o  (frame_end),
        .strobe_o     (strobe),
        .strobe_dly_o (strobe_dly)
    );

    ilv_ser_capture #(
        .GROUP_W    (GROUP_W),
        .COMMA_WORD (COMMA_WORD)
    ) capture_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (strobe),
        .strobe_dly_i (strobe_dly),
        .lo_i         (par_data_i[GROUP_W-1:0]),
        .hi_i         (par_data_i[WORD_W-1:GROUP_W]),
        .full_i       (full_rate_i),
        .comma_i      (comma_en_i),
        .pp_i         (pingpong_i),
        .lo_o         (cap_lo),
        .hi_o         (cap_hi),
        .rate_o       (cap_rate)
    );

    assign word       = {cap_hi, cap_lo};
    assign bank_shift = phase && !frame_end;

    // Bank 0 takes the even bits, bank 1 the odd bits; in half rate bank 0
    // takes the lower group in order and bank 1 is idle.
    for (genvar j = 0; j < GROUP_W; j++) begin : g_bit_order
        assign bank_val[0][j] = (cap_rate == RATE_FULL) ? word[2*j]   : cap_lo[j];
        assign bank_val[1][j] = (cap_rate == RATE_FULL) ? word[2*j+1] : 1'b0;
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        ilv_ser_bank #(
            .GROUP_W (GROUP_W)
        ) bank_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (frame_end),
            .shift_i    (bank_shift),
            .load_val_i (bank_val[b]),
            .head_o     (bank_head[b])
        );
    end

    always_comb begin
        top_d      = top_q;
        top_d.rate = frame_end ? cap_rate : top_q.rate;
        top_d.ser  = (top_q.rate == RATE_FULL && phase) ? bank_head[1] : bank_head[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q      <= '0;
            top_q.rate <= RATE_FULL;
        end else begin
            top_q <= top_d;
        end
    end

    assign ser_o          = top_q.ser;
    assign frame_strobe_o = strobe;

    a_r4_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.rate == RATE_HALF && phase) |=> $stable(top_q.ser));

    a_r8_rate_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(top_q.rate));

endmodule

// File: tb/ilv_serializer_tb_top.sv
module ilv_serializer_tb_top;
    localparam int GW = 10;
    localparam int FW = 2 * GW;
    localparam int NF = 60;
    // Comma word, sent first-to-last as 0,0,1,1,1,1,1,0,1,0 (R5).
    localparam logic [GW-1:0] K_SEND = 10'b0101111100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] par = '0;
    logic          full = 1'b1, comma = 1'b0, pp = 1'b0;
    logic          ser, strobe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ilv_serializer dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .par_data_i     (par),
        .full_rate_i    (full),
        .comma_en_i     (comma),
        .pingpong_i     (pp),
        .ser_o          (ser),
        .frame_strobe_o (strobe)
    );

    // Entry i is the serial bit expected in cycle i+1 after the next strobe.
    function automatic logic [FW-1:0] timeline(input logic f_full, input logic f_comma,
                                               input logic [GW-1:0] lo, input logic [GW-1:0] hi);
        logic [GW-1:0] l2, h2;
        logic [FW-1:0] w, t;
        l2 = f_comma ? K_SEND : lo;
        h2 = f_comma ? K_SEND : hi;
        w  = {h2, l2};
        for (int i = 0; i < FW; i++) begin
            t[i] = f_full ? w[i] : l2[i/2];
        end
        return t;
    endfunction

    task automatic chk(input string tag, input string what, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%0b exp=%0b", tag, what, got, exp);
        end
    endtask

    task automatic pick(input int f);
        full  = ($urandom % 2) == 0;
        comma = ($urandom % 6) == 0;
        pp    = ($urandom % 2) == 0;
        par   = FW'($urandom);
        case (f)
            0: begin full = 1; comma = 0; pp = 0; par = 20'hA5C3F; end
            1: begin full = 0; comma = 0; pp = 0; par = 20'hFFFFF; end
            2: begin full = 1; comma = 1; pp = 0; end
            3: begin full = 0; comma = 1; pp = 1; end
            4: begin full = 1; comma = 0; pp = 1; par = 20'h12345; end
            5: begin full = 1; comma = 0; pp = 0; par = 20'h003FF; end
            6: begin full = 0; comma = 0; pp = 1; par = 20'h5A3C6; end
            7: begin full = 1; comma = 1; pp = 1; end
            default: ;
        endcase
    endtask

    initial begin
        logic [FW-1:0] e1, e2, ecur;
        string         t1, t2, tcur;
        logic          c_full, c_comma, c_pp;
        logic [GW-1:0] c_lo, c_hi, alt;
        int            n;
        void'($urandom(32'd4242));
        pick(0);
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1", "strobe in reset", strobe, 1'b0);
            chk("R1", "ser in reset", ser, 1'b0);
        end
        rst_n = 1'b1;
        n = 0;
        while (n < 40) begin
            @(negedge clk);
            n++;
            if (strobe) break;
            chk("R1", "ser before first frame", ser, 1'b0);
        end
        total++;
        if (n != 20) begin
            bad++;
            $display("FAIL R1 first strobe cycle: got=%0d exp=20", n);
        end
        e1 = '0; e2 = '0; t1 = "R1"; t2 = "R1";
        ecur = '0;
        for (int f = 0; f < NF; f++) begin
            c_full  = full;
            c_comma = comma;
            c_pp    = pp;
            c_lo    = par[GW-1:0];
            c_hi    = par[FW-1:GW];
            tcur    = c_comma ? "R5" : (!c_full ? "R4" : (c_pp ? "R6" : "R3 R7"));
            for (int m = 0; m < FW; m++) begin
                if (m > 0) @(negedge clk);
                chk("R2", "frame strobe", strobe, m == 0);
                if (m == 0) chk(t2, "ser (R8 inputs toggled)", ser, e2[FW-1]);
                else        chk(t1, "ser (R8 inputs toggled)", ser, e1[m-1]);
                if (m == 1) begin
                    // Upper group changes one cycle after the strobe (R6/R7).
                    alt = (f == 5) ? ~c_hi : GW'($urandom);
                    par[FW-1:GW] = alt;
                    ecur = timeline(c_full, c_comma, c_lo, c_pp ? alt : c_hi);
                end
                if (m == 2) begin
                    // Scramble inputs between strobes (R8).
                    full  = ($urandom % 2) == 0;
                    comma = ($urandom % 2) == 0;
                    pp    = ($urandom % 2) == 0;
                    par   = FW'($urandom);
                end
                if (m == 18) pick(f + 1);
            end
            e2 = e1; t2 = t1;
            e1 = ecur; t1 = tcur;
            @(negedge clk);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog: got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule